// File: doc/BRIEF.md
# UART Interrupt Identification Unit

This unit sits beside the receive path, the transmit path and the modem-status logic of a 16550-style serial port. It turns their raw conditions into one interrupt request line and an 8-bit identification value that software reads to find out why it was interrupted. The five sources are line-status error, receive data at or above the trigger level, receive character timeout, transmit holding register empty, and modem status change. A 4-bit enable register gates them. A fixed priority picks the single source that is reported.

Some sources are held in sticky flags inside the unit. These flags clear on the register accesses that service them: a line-status read, a receive-data read, a modem-status read, a transmit-holding write, or an identification read that shows the transmit-empty code. The receive-data source is a level that comes straight from the receive FIFO. Serial shifting, FIFO storage, baud generation and address decoding sit outside the unit. They reach it only as single-cycle strobes and level inputs.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset `iir` reads 0xC1, `irq` is 0 and `ier_q` is 0.
- R2: Bits 7:4 of `iir` always read 0xC. Bit 0 reads 1 exactly when no enabled source is pending. `irq` is always the inverse of bit 0.
- R3: The low nibble of `iir` reports the winning source as 0x6 for line status, 0x4 for receive data, 0xC for character timeout, 0x2 for transmit empty and 0x0 for modem status.
- R4: Enable bit 0 gates receive data and timeout, bit 1 gates transmit empty, bit 2 gates line status and bit 3 gates modem status. A pending source whose enable is 0 is never reported and never drives `irq`.
- R5: When several enabled sources are pending, only the highest is reported. The order from highest to lowest is line status, receive data, timeout, transmit empty, modem status.
- R6: A pulse on `lsr_err_evt` latches the line-status source. A `rd_lsr` strobe clears it, and the change shows from the next cycle.
- R7: The receive-data source follows `rx_at_trig` combinationally, with no latching. While enable bit 0 is 0, the level has no effect on `iir` or `irq`.
- R8: A pulse on `rx_timeout_evt` latches the timeout source. A `rd_rbr` strobe clears it.
- R9: The transmit-empty source is set by a rising edge of `thr_empty`, or by a write that changes enable bit 1 from 0 to 1 while `thr_empty` is 1. A write that keeps bit 1 at 1 does not set it again. The source is cleared by `wr_thr`, or by `rd_iir` in a cycle where `iir` shows 0x2. An `rd_iir` while another code is shown leaves it pending.
- R10: A pulse on `msr_delta_evt` latches the modem source. A `rd_msr` strobe clears it.
- R11: If a set and a clear of the same source fall in the same cycle, the set wins.
- R12: An `ier_wr` strobe loads `ier_wdata` into `ier_q` at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ier_wr | input | 1 | Write strobe for the enable register |
| ier_wdata | input | IER_W | Enable register write data |
| ier_q | output | IER_W | Current enable register value |
| lsr_err_evt | input | 1 | Line error event pulse (overrun, parity, framing, break) |
| rx_at_trig | input | 1 | Receive FIFO level at or above the trigger (level) |
| rx_timeout_evt | input | 1 | Character timeout event pulse |
| thr_empty | input | 1 | Transmit holding register empty (level) |
| msr_delta_evt | input | 1 | Modem status change event pulse |
| rd_iir | input | 1 | Identification register read strobe |
| rd_lsr | input | 1 | Line status register read strobe |
| rd_rbr | input | 1 | Receive buffer read strobe |
| rd_msr | input | 1 | Modem status register read strobe |
| wr_thr | input | 1 | Transmit holding register write strobe |
| iir | output | 8 | Encoded identification value |
| irq | output | 1 | Interrupt request, high while an enabled source is pending |

## Verification
A sticky flag stuck at the wrong value shows up at `iir` in the cycle after the event or access that should have moved it. It shows up only if the source is enabled and no higher-priority source masks it. For that reason, every source is checked both alone and under every combination of the other sources and of all sixteen enable settings. A wrong priority, a wrong enable mapping or a wrong code is then visible at once. Faults in the clear paths show only after a specific access. Directed sequences therefore read the identification value one cycle after each clearing access, after an identification read that a higher code hides, and after a set and a clear that land in the same cycle.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  // Source indices, ordered from highest to lowest priority.
  localparam int NSRC     = 5;
  localparam int SRC_LS   = 0;
  localparam int SRC_RDA  = 1;
  localparam int SRC_TO   = 2;
  localparam int SRC_THRE = 3;
  localparam int SRC_MS   = 4;

  localparam int IER_W    = 4;
  localparam int IIR_W    = 8;

  localparam logic [3:0] IIR_HI   = 4'hC;  // FIFO-mode marker in the upper nibble
  localparam logic [3:0] NIB_IDLE = 4'h1;  // nothing pending

  function automatic logic [3:0] src_code(input int idx);
    case (idx)
      SRC_LS:   return 4'h6;
      SRC_RDA:  return 4'h4;
      SRC_TO:   return 4'hC;
      SRC_THRE: return 4'h2;
      default:  return 4'h0;
    endcase
  endfunction

  function automatic int src_en_bit(input int idx);
    case (idx)
      SRC_LS:   return 2;
      SRC_RDA:  return 0;
      SRC_TO:   return 0;
      SRC_THRE: return 1;
      default:  return 3;
    endcase
  endfunction

endpackage

// File: rtl/uart_irq_enable_reg.sv
module uart_irq_enable_reg #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] q_next;

  always_comb begin
    q_next = q_o;
    if (wr_i) q_next = wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= '0;
    else        q_o <= q_next;
  end

  a_r12_load: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> (q_o == $past(wdata_i)));

endmodule

// File: rtl/uart_irq_flag.sv
module uart_irq_flag #(
  parameter bit SET_WINS = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);

  logic q_next;

  generate
    if (SET_WINS) begin : g_set_first
      always_comb begin
        q_next = q_o;
        if (clr_i) q_next = 1'b0;
        if (set_i) q_next = 1'b1;
      end
      // R11: a set in the same cycle as a clear leaves the flag pending
      a_r11_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> q_o);
    end else begin : g_clr_first
      always_comb begin
        q_next = q_o;
        if (set_i) q_next = 1'b1;
        if (clr_i) q_next = 1'b0;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= 1'b0;
    else        q_o <= q_next;
  end

endmodule

// File: rtl/uart_irq_prio_enc.sv
module uart_irq_prio_enc
  import uart_irq_pkg::*;
#(
  parameter int N = NSRC
) (
  input  logic [N-1:0]     req_i,
  output logic [IIR_W-1:0] iir_o,
  output logic             irq_o
);

  logic [3:0] nib;

  always_comb begin
    nib = NIB_IDLE;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) nib = src_code(i);
    end
  end

  assign iir_o = {IIR_HI, nib};
  assign irq_o = |req_i;

endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
#(
  parameter int IER_W_P = IER_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ier_wr,
  input  logic [IER_W_P-1:0] ier_wdata,
  output logic [IER_W_P-1:0] ier_q,
  input  logic               lsr_err_evt,
  input  logic               rx_at_trig,
  input  logic               rx_timeout_evt,
  input  logic               thr_empty,
  input  logic               msr_delta_evt,
  input  logic               rd_iir,
  input  logic               rd_lsr,
  input  logic               rd_rbr,
  input  logic               rd_msr,
  input  logic               wr_thr,
  output logic [IIR_W-1:0]   iir,
  output logic               irq
);

  logic [NSRC-1:0] pend;
  logic [NSRC-1:0] en_v;
  logic            ls_q, to_q, thre_q, ms_q;
  logic            thr_d, thr_d_next;
  logic            thre_set, thre_clr;

  // Enable register
  uart_irq_enable_reg #(.W(IER_W_P)) u_ier (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (ier_wr),
    .wdata_i (ier_wdata),
    .q_o     (ier_q)
  );

  // Edge detector on the transmit-empty level
  assign thr_d_next = thr_empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) thr_d <= 1'b1;
    else        thr_d <= thr_d_next;
  end

  always_comb begin
    thre_set = (thr_empty && !thr_d) ||
               (ier_wr && ier_wdata[src_en_bit(SRC_THRE)] &&
                !ier_q[src_en_bit(SRC_THRE)] && thr_empty);
    thre_clr = wr_thr || (rd_iir && (iir[3:0] == src_code(SRC_THRE)));
  end

  // Sticky sources
  uart_irq_flag #(.SET_WINS(1'b1)) u_ls (
    .clk(clk), .rst_n(rst_n), .set_i(lsr_err_evt), .clr_i(rd_lsr), .q_o(ls_q));

  uart_irq_flag #(.SET_WINS(1'b1)) u_to (
    .clk(clk), .rst_n(rst_n), .set_i(rx_timeout_evt), .clr_i(rd_rbr), .q_o(to_q));

  uart_irq_flag #(.SET_WINS(1'b1)) u_thre (
    .clk(clk), .rst_n(rst_n), .set_i(thre_set), .clr_i(thre_clr), .q_o(thre_q));

  uart_irq_flag #(.SET_WINS(1'b1)) u_ms (
    .clk(clk), .rst_n(rst_n), .set_i(msr_delta_evt), .clr_i(rd_msr), .q_o(ms_q));

  always_comb begin
    pend           = '0;
    pend[SRC_LS]   = ls_q;
    pend[SRC_RDA]  = rx_at_trig;
    pend[SRC_TO]   = to_q;
    pend[SRC_THRE] = thre_q;
    pend[SRC_MS]   = ms_q;
  end

  // Per-source enable selection
  generate
    for (genvar i = 0; i < NSRC; i++) begin : g_en
      assign en_v[i] = ier_q[src_en_bit(i)];
    end
  endgenerate

  uart_irq_prio_enc #(.N(NSRC)) u_enc (
    .req_i (pend & en_v),
    .iir_o (iir),
    .irq_o (irq)
  );

  // R2: request line and the idle bit agree
  a_r2_irq_bit0: assert property (@(posedge clk) disable iff (!rst_n)
    irq == !iir[0]);

  // R4: nothing enabled, nothing requested
  a_r4_all_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (ier_q == '0) |-> !irq);

  // R5/R6: an enabled line error wins the next cycle
  a_r5_ls_top: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr_err_evt && ier_q[src_en_bit(SRC_LS)] && !ier_wr) |=> (iir == 8'hC6));

  // R6: line status read clears the source
  a_r6_lsr_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_lsr && !lsr_err_evt) |=> (iir[3:0] != 4'h6));

  // R8: receive read clears the timeout
  a_r8_to_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rbr && !rx_timeout_evt) |=> (iir[3:0] != 4'hC));

  // R9: holding write with the register full leaves no transmit-empty code
  a_r9_thre_wr: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_thr && !thr_empty) |=> (iir[3:0] != 4'h2));

  // R10: modem status read clears the modem source
  a_r10_ms_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_msr && !msr_delta_evt) |=> (iir != 8'hC0));

endmodule

// File: tb/uart_irq_ident_test.sv
module uart_irq_ident_test;

  localparam int CLK_PERIOD = 10;

  logic       clk;
  logic       rst_n;
  logic       ier_wr;
  logic [3:0] ier_wdata;
  logic [3:0] ier_q;
  logic       lsr_err_evt, rx_at_trig, rx_timeout_evt, thr_empty, msr_delta_evt;
  logic       rd_iir, rd_lsr, rd_rbr, rd_msr, wr_thr;
  logic [7:0] iir;
  logic       irq;

  int checks;
  int errors;
  bit done;

  uart_irq_ident uut (
    .clk(clk), .rst_n(rst_n), .ier_wr(ier_wr), .ier_wdata(ier_wdata), .ier_q(ier_q),
    .lsr_err_evt(lsr_err_evt), .rx_at_trig(rx_at_trig), .rx_timeout_evt(rx_timeout_evt),
    .thr_empty(thr_empty), .msr_delta_evt(msr_delta_evt), .rd_iir(rd_iir),
    .rd_lsr(rd_lsr), .rd_rbr(rd_rbr), .rd_msr(rd_msr), .wr_thr(wr_thr),
    .iir(iir), .irq(irq)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD / 2) clk = ~clk;
  end

  function automatic logic [7:0] model_iir(input logic [3:0] en, input logic ls,
                                           input logic rda, input logic to,
                                           input logic thre, input logic ms);
    if (en[2] && ls)        return 8'hC6;
    else if (en[0] && rda)  return 8'hC4;
    else if (en[0] && to)   return 8'hCC;
    else if (en[1] && thre) return 8'hC2;
    else if (en[3] && ms)   return 8'hC0;
    else                    return 8'hC1;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  // Wait for the edge, return pulses to idle, sample away from the edge.
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    ier_wr = 1'b0; lsr_err_evt = 1'b0; rx_timeout_evt = 1'b0; msr_delta_evt = 1'b0;
    rd_iir = 1'b0; rd_lsr = 1'b0; rd_rbr = 1'b0; rd_msr = 1'b0; wr_thr = 1'b0;
    #1;
  endtask

  task automatic set_ier(input logic [3:0] v);
    ier_wr = 1'b1; ier_wdata = v;
    tick();
  endtask

  task automatic clean(input logic [3:0] v);
    ier_wr = 1'b1; ier_wdata = v;
    rd_lsr = 1'b1; rd_rbr = 1'b1; rd_msr = 1'b1; wr_thr = 1'b1;
    thr_empty = 1'b0; rx_at_trig = 1'b0;
    tick();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    checks = 0; errors = 0; done = 1'b0;
    rst_n = 1'b0; ier_wr = 1'b0; ier_wdata = 4'h0;
    lsr_err_evt = 1'b0; rx_at_trig = 1'b0; rx_timeout_evt = 1'b0;
    thr_empty = 1'b0; msr_delta_evt = 1'b0;
    rd_iir = 1'b0; rd_lsr = 1'b0; rd_rbr = 1'b0; rd_msr = 1'b0; wr_thr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1 iir", iir, 8'hC1);
    chk("R1 irq", {7'd0, irq}, 8'h00);
    chk("R1 ier", {4'd0, ier_q}, 8'h00);

    // R2 R3 R4 R5 R7: every enable setting against every source combination
    for (int e = 0; e < 16; e++) begin
      for (int c = 0; c < 32; c++) begin
        logic [7:0] exp;
        clean(e[3:0]);
        lsr_err_evt    = c[0];
        rx_at_trig     = c[1];
        rx_timeout_evt = c[2];
        thr_empty      = c[3];
        msr_delta_evt  = c[4];
        tick();
        exp = model_iir(e[3:0], c[0], c[1], c[2], c[3], c[4]);
        chk("R5 sweep iir", iir, exp);
        chk("R2 sweep irq", {7'd0, irq}, {7'd0, exp[0] == 1'b0});
      end
    end

    // R9: set and clear in the same cycle while disabled, then plain clear
    clean(4'h0);
    thr_empty = 1'b1; wr_thr = 1'b1;
    tick();
    chk("R4 masked thre", iir, 8'hC1);
    wr_thr = 1'b1;
    tick();
    set_ier(4'h2);
    chk("R9 enable while empty", iir, 8'hC2);
    chk("R9 irq", {7'd0, irq}, 8'h01);
    rd_iir = 1'b1;
    tick();
    chk("R9 iir read clears", iir, 8'hC1);
    set_ier(4'h6);
    chk("R9 no retrigger", iir, 8'hC1);

    // R6 and priority masking of an identification read
    lsr_err_evt = 1'b1;
    tick();
    chk("R6 ls set", iir, 8'hC6);
    set_ier(4'h4);
    set_ier(4'h6);
    chk("R5 ls over thre", iir, 8'hC6);
    rd_iir = 1'b1;
    tick();
    chk("R9 hidden read keeps", iir, 8'hC6);
    rd_lsr = 1'b1;
    tick();
    chk("R6 lsr read clears", iir, 8'hC2);
    wr_thr = 1'b1; thr_empty = 1'b0;
    tick();
    chk("R9 thr write clears", iir, 8'hC1);

    // R10 R11 modem source
    set_ier(4'h8);
    msr_delta_evt = 1'b1; rd_msr = 1'b1;
    tick();
    chk("R11 set wins", iir, 8'hC0);
    rd_msr = 1'b1;
    tick();
    chk("R10 msr read clears", iir, 8'hC1);

    // R8 timeout
    set_ier(4'h1);
    rx_timeout_evt = 1'b1;
    tick();
    chk("R8 timeout set", iir, 8'hCC);
    rd_rbr = 1'b1;
    tick();
    chk("R8 rbr read clears", iir, 8'hC1);

    // R7 receive level
    set_ier(4'h0);
    rx_at_trig = 1'b1;
    tick();
    chk("R7 disabled level", iir, 8'hC1);
    chk("R7 disabled irq", {7'd0, irq}, 8'h00);
    set_ier(4'h1);
    chk("R7 enabled level", iir, 8'hC4);
    rx_at_trig = 1'b0;
    #1;
    chk("R7 level drop", iir, 8'hC1);

    // R12 enable readback
    set_ier(4'hF);
    chk("R12 ier F", {4'd0, ier_q}, 8'h0F);
    set_ier(4'h5);
    chk("R12 ier 5", {4'd0, ier_q}, 8'h05);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule